// File: doc/BRIEF.md
# Trap-Return Status Update Unit

This unit carries out the two trap-return instructions of a RISC-V style core, the supervisor return and the machine return. The core may include the optional hypervisor extension. The core presents a request strobe with:

- the current privilege level and virtualization flag;
- the interrupt-enable and previous-mode fields of the machine status register;
- the previous-virtualization and virtual-trap bits of the hypervisor status register;
- a strap that says whether the hypervisor extension is built in;
- a flag that says whether any memory-protection rule is configured;
- bit 1 of the return target and whether compressed instructions are enabled.

One clock cycle later the unit returns the rewritten status fields, the new privilege and virtualization state, and one of two results. Either a completion pulse and, when the return enters virtualized mode, a pulse that asks for the hypervisor register bank to be swapped. Or an exception with its cause code, in which case every field comes back unchanged.

The legality checks run in a fixed priority, and the first failing check sets the cause. Fetching from the target, storing the status registers and delivering interrupts are done elsewhere in the core.

Top module: `trap_return_unit`

## Requirements
- R1: Encodings are user = 0, supervisor = 1, machine = 3. A supervisor return (req_mret = 0) with cur_priv = 0 raises exception cause 2. This check has the highest priority.
- R2: A target with tgt_bit1 = 1 while rvc_enabled = 0 raises cause 0. This check applies to both returns, one step below the privilege check.
- R3: A supervisor return with st_tsr = 1 and cur_priv other than 3 raises cause 2. This check sits below misalignment.
- R4: A supervisor return with hyp_present = 1, cur_virt = 1 and hs_vtsr = 1 raises cause 22. This is the lowest-priority supervisor check.
- R5: A machine return with cur_priv other than 3 raises cause 2. This check sits above misalignment.
- R6: A machine return with pmp_active = 0 and st_mpp other than 3 raises cause 2. This check sits below misalignment.
- R7: When an exception is raised, exc_valid pulses, done stays 0, bank_swap stays 0, and every nx_* output equals the corresponding input of that request.
- R8: A legal supervisor return with hyp_present = 1 and cur_virt = 0 produces the following: nx_priv = {0, st_spp}, nx_virt = hs_spv, nx_spv = 0, nx_spp = 0, nx_sie = st_spie and nx_spie = 1.
- R9: Any other legal supervisor return produces nx_sie = st_spie, nx_spie = 1, nx_spp = 0, nx_priv = {0, st_spp}, and leaves nx_virt and nx_spv as they were on input.
- R10: A legal machine return produces nx_mie = st_mpie, nx_mpie = 1, nx_mpp = 0, nx_mpv = 0 and nx_priv = st_mpp.
- R11: A legal machine return sets nx_virt = st_mpv when hyp_present = 1, and keeps nx_virt = cur_virt otherwise.
- R12: bank_swap pulses together with done exactly when a legal return moves nx_virt from 0 to 1.
- R13: Results appear on the clock edge that follows the request. Between requests, done, exc_valid and bank_swap are 0 and the nx_* outputs hold their values.
- R14: After reset, nx_priv = 3 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, one cycle per return |
| req_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege level |
| cur_virt | input | 1 | Current virtualization flag |
| hyp_present | input | 1 | Hypervisor extension strap |
| pmp_active | input | 1 | At least one protection rule configured |
| rvc_enabled | input | 1 | Compressed instructions enabled |
| tgt_bit1 | input | 1 | Bit 1 of the return target |
| st_tsr | input | 1 | Trap-supervisor-return bit |
| st_sie | input | 1 | Supervisor interrupt enable |
| st_spie | input | 1 | Supervisor previous interrupt enable |
| st_spp | input | 1 | Supervisor previous privilege |
| st_mie | input | 1 | Machine interrupt enable |
| st_mpie | input | 1 | Machine previous interrupt enable |
| st_mpp | input | 2 | Machine previous privilege |
| st_mpv | input | 1 | Machine previous virtualization |
| hs_spv | input | 1 | Hypervisor supervisor previous virtualization |
| hs_vtsr | input | 1 | Virtual trap-supervisor-return bit |
| done | output | 1 | Legal return completed |
| exc_valid | output | 1 | Exception raised |
| exc_cause | output | 5 | Exception cause code |
| nx_sie | output | 1 | Updated supervisor interrupt enable |
| nx_spie | output | 1 | Updated supervisor previous enable |
| nx_spp | output | 1 | Updated supervisor previous privilege |
| nx_mie | output | 1 | Updated machine interrupt enable |
| nx_mpie | output | 1 | Updated machine previous enable |
| nx_mpp | output | 2 | Updated machine previous privilege |
| nx_mpv | output | 1 | Updated machine previous virtualization |
| nx_spv | output | 1 | Updated hypervisor previous virtualization |
| nx_priv | output | 2 | New privilege level |
| nx_virt | output | 1 | New virtualization flag |
| bank_swap | output | 1 | Request to swap the hypervisor register bank |

## Verification
The assertions take for granted that the core presents at most one request per cycle, and that every input is stable and meaningful in any cycle where req is high. They also assume that cur_priv only ever takes the value 2 as a deliberate probe of the reserved encoding. The stimulus issues one request per cycle with every input driven on the falling edge. It walks every combination of the return type, privilege (reserved code included), virtualization, straps, target bit, trap bits and previous-mode fields. Each enable bit is tied to the inverse of its previous-enable partner, so that a copy from one to the other always shows up as a change. A final idle cycle confirms that nothing pulses and every field holds.

// File: rtl/trp_pkg.sv
package trp_pkg;

  localparam int PRIV_W  = 2;
  localparam int CAUSE_W = 5;

  localparam logic [PRIV_W-1:0] PRIV_U = 2'd0;
  localparam logic [PRIV_W-1:0] PRIV_S = 2'd1;
  localparam logic [PRIV_W-1:0] PRIV_M = 2'd3;

  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRT     = 5'd22;

  typedef struct packed {
    logic              sie;
    logic              spie;
    logic              spp;
    logic              mie;
    logic              mpie;
    logic [PRIV_W-1:0] mpp;
    logic              mpv;
    logic              spv;
    logic [PRIV_W-1:0] priv;
    logic              virt;
  } trp_state_t;

  function automatic logic target_misaligned(input logic bit1, input logic rvc_on);
    return bit1 & ~rvc_on;
  endfunction

  function automatic logic enters_virt(input logic old_virt, input logic new_virt);
    return new_virt & ~old_virt;
  endfunction

endpackage

// File: rtl/trp_legality.sv
module trp_legality
  import trp_pkg::*;
(
  input  logic               is_mret,
  input  logic [PRIV_W-1:0]  priv,
  input  logic               virt,
  input  logic               hyp,
  input  logic               pmp_on,
  input  logic               misal,
  input  logic               tsr,
  input  logic               vtsr,
  input  logic [PRIV_W-1:0]  mpp,
  output logic               exc,
  output logic [CAUSE_W-1:0] cause
);

  always_comb begin
    exc   = 1'b0;
    cause = CAUSE_MISALIGN;
    if (is_mret) begin
      if (priv != PRIV_M) begin
        exc = 1'b1; cause = CAUSE_ILLEGAL;
      end else if (misal) begin
        exc = 1'b1; cause = CAUSE_MISALIGN;
      end else if (!pmp_on && mpp != PRIV_M) begin
        exc = 1'b1; cause = CAUSE_ILLEGAL;
      end
    end else begin
      if (priv < PRIV_S) begin
        exc = 1'b1; cause = CAUSE_ILLEGAL;
      end else if (misal) begin
        exc = 1'b1; cause = CAUSE_MISALIGN;
      end else if (tsr && priv != PRIV_M) begin
        exc = 1'b1; cause = CAUSE_ILLEGAL;
      end else if (hyp && virt && vtsr) begin
        exc = 1'b1; cause = CAUSE_VIRT;
      end
    end
  end

endmodule

// File: rtl/trp_sret_xform.sv
module trp_sret_xform
  import trp_pkg::*;
(
  input  trp_state_t cur,
  input  logic       hyp,
  output trp_state_t nxt
);

  always_comb begin
    nxt      = cur;
    nxt.sie  = cur.spie;
    nxt.spie = 1'b1;
    nxt.spp  = 1'b0;
    nxt.priv = {1'b0, cur.spp};
    if (hyp && !cur.virt) begin
      nxt.virt = cur.spv;
      nxt.spv  = 1'b0;
    end
  end

endmodule

// File: rtl/trp_mret_xform.sv
module trp_mret_xform
  import trp_pkg::*;
(
  input  trp_state_t cur,
  input  logic       hyp,
  output trp_state_t nxt
);

  always_comb begin
    nxt      = cur;
    nxt.mie  = cur.mpie;
    nxt.mpie = 1'b1;
    nxt.mpp  = PRIV_U;
    nxt.mpv  = 1'b0;
    nxt.priv = cur.mpp;
    if (hyp) nxt.virt = cur.mpv;
  end

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               req_mret,
  input  logic [PRIV_W-1:0]  cur_priv,
  input  logic               cur_virt,
  input  logic               hyp_present,
  input  logic               pmp_active,
  input  logic               rvc_enabled,
  input  logic               tgt_bit1,
  input  logic               st_tsr,
  input  logic               st_sie,
  input  logic               st_spie,
  input  logic               st_spp,
  input  logic               st_mie,
  input  logic               st_mpie,
  input  logic [PRIV_W-1:0]  st_mpp,
  input  logic               st_mpv,
  input  logic               hs_spv,
  input  logic               hs_vtsr,
  output logic               done,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic               nx_sie,
  output logic               nx_spie,
  output logic               nx_spp,
  output logic               nx_mie,
  output logic               nx_mpie,
  output logic [PRIV_W-1:0]  nx_mpp,
  output logic               nx_mpv,
  output logic               nx_spv,
  output logic [PRIV_W-1:0]  nx_priv,
  output logic               nx_virt,
  output logic               bank_swap
);

  trp_state_t         cur_st, sret_st, mret_st, sel_st, state_q;
  logic               misal_w;
  logic               exc_w;
  logic [CAUSE_W-1:0] cause_w;
  logic               swap_w;

  assign cur_st = '{sie: st_sie, spie: st_spie, spp: st_spp, mie: st_mie,
                    mpie: st_mpie, mpp: st_mpp, mpv: st_mpv, spv: hs_spv,
                    priv: cur_priv, virt: cur_virt};

  assign misal_w = target_misaligned(tgt_bit1, rvc_enabled);

  trp_legality u_legal (
    .is_mret (req_mret),
    .priv    (cur_priv),
    .virt    (cur_virt),
    .hyp     (hyp_present),
    .pmp_on  (pmp_active),
    .misal   (misal_w),
    .tsr     (st_tsr),
    .vtsr    (hs_vtsr),
    .mpp     (st_mpp),
    .exc     (exc_w),
    .cause   (cause_w)
  );

  trp_sret_xform u_sret (.cur(cur_st), .hyp(hyp_present), .nxt(sret_st));
  trp_mret_xform u_mret (.cur(cur_st), .hyp(hyp_present), .nxt(mret_st));

  always_comb begin
    if (exc_w)         sel_st = cur_st;
    else if (req_mret) sel_st = mret_st;
    else               sel_st = sret_st;
  end

  assign swap_w = ~exc_w & enters_virt(cur_virt, sel_st.virt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= '0;
      state_q.priv <= PRIV_M;
      done         <= 1'b0;
      exc_valid    <= 1'b0;
      exc_cause    <= '0;
      bank_swap    <= 1'b0;
    end else if (req) begin
      state_q   <= sel_st;
      done      <= ~exc_w;
      exc_valid <= exc_w;
      bank_swap <= swap_w;
      if (exc_w) exc_cause <= cause_w;
    end else begin
      done      <= 1'b0;
      exc_valid <= 1'b0;
      bank_swap <= 1'b0;
    end
  end

  assign nx_sie  = state_q.sie;
  assign nx_spie = state_q.spie;
  assign nx_spp  = state_q.spp;
  assign nx_mie  = state_q.mie;
  assign nx_mpie = state_q.mpie;
  assign nx_mpp  = state_q.mpp;
  assign nx_mpv  = state_q.mpv;
  assign nx_spv  = state_q.spv;
  assign nx_priv = state_q.priv;
  assign nx_virt = state_q.virt;

endmodule

// File: rtl/trap_return_sva.sv
module trap_return_sva
  import trp_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req,
  input logic               req_mret,
  input logic [PRIV_W-1:0]  cur_priv,
  input logic               cur_virt,
  input logic               hyp_present,
  input logic               hs_vtsr,
  input logic               exc_w,
  input logic               done,
  input logic               exc_valid,
  input logic [CAUSE_W-1:0] exc_cause,
  input logic               nx_spie,
  input logic               nx_spp,
  input logic               nx_mpie,
  input logic [PRIV_W-1:0]  nx_mpp,
  input logic [PRIV_W-1:0]  nx_priv,
  input logic               nx_virt,
  input logic               bank_swap
);

  a_r13_result_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    (done || exc_valid) |-> $past(req));

  a_r7_exc_excludes_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && exc_valid));

  a_r7_exc_keeps_priv: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (nx_priv == $past(cur_priv) && nx_virt == $past(cur_virt)));

  a_r12_swap_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    bank_swap |-> (done && nx_virt && !$past(cur_virt)));

  a_r10_mret_clears_mpp: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(req_mret)) |-> (nx_mpp == PRIV_U && nx_mpie));

  a_r9_sret_sets_spie: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(req_mret)) |-> (nx_spie && !nx_spp));

  a_r4_virt_cause_source: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_cause == CAUSE_VIRT) |->
      $past(!req_mret && hyp_present && cur_virt && hs_vtsr));

  a_r13_exc_registered: assert property (@(posedge clk) disable iff (!rst_n)
    (req && exc_w) |=> exc_valid);

endmodule

bind trap_return_unit trap_return_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .req         (req),
  .req_mret    (req_mret),
  .cur_priv    (cur_priv),
  .cur_virt    (cur_virt),
  .hyp_present (hyp_present),
  .hs_vtsr     (hs_vtsr),
  .exc_w       (exc_w),
  .done        (done),
  .exc_valid   (exc_valid),
  .exc_cause   (exc_cause),
  .nx_spie     (nx_spie),
  .nx_spp      (nx_spp),
  .nx_mpie     (nx_mpie),
  .nx_mpp      (nx_mpp),
  .nx_priv     (nx_priv),
  .nx_virt     (nx_virt),
  .bank_swap   (bank_swap)
);

// File: tb/trap_return_unit_bench.sv
module trap_return_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 131072;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 0, req_mret = 0, cur_virt = 0, hyp_present = 0, pmp_active = 0;
  logic rvc_enabled = 0, tgt_bit1 = 0, st_tsr = 0, st_sie = 0, st_spie = 0;
  logic st_spp = 0, st_mie = 0, st_mpie = 0, st_mpv = 0, hs_spv = 0, hs_vtsr = 0;
  logic [1:0] cur_priv = 0, st_mpp = 0;
  logic done, exc_valid, nx_sie, nx_spie, nx_spp, nx_mie, nx_mpie, nx_mpv;
  logic nx_spv, nx_virt, bank_swap;
  logic [4:0] exc_cause;
  logic [1:0] nx_mpp, nx_priv;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_return_unit u_trap_return_unit (
    .clk(clk), .rst_n(rst_n), .req(req), .req_mret(req_mret),
    .cur_priv(cur_priv), .cur_virt(cur_virt), .hyp_present(hyp_present),
    .pmp_active(pmp_active), .rvc_enabled(rvc_enabled), .tgt_bit1(tgt_bit1),
    .st_tsr(st_tsr), .st_sie(st_sie), .st_spie(st_spie), .st_spp(st_spp),
    .st_mie(st_mie), .st_mpie(st_mpie), .st_mpp(st_mpp), .st_mpv(st_mpv),
    .hs_spv(hs_spv), .hs_vtsr(hs_vtsr), .done(done), .exc_valid(exc_valid),
    .exc_cause(exc_cause), .nx_sie(nx_sie), .nx_spie(nx_spie), .nx_spp(nx_spp),
    .nx_mie(nx_mie), .nx_mpie(nx_mpie), .nx_mpp(nx_mpp), .nx_mpv(nx_mpv),
    .nx_spv(nx_spv), .nx_priv(nx_priv), .nx_virt(nx_virt), .bank_swap(bank_swap)
  );

  function automatic logic [11:0] out_fields();
    return {nx_sie, nx_spie, nx_spp, nx_mie, nx_mpie, nx_mpp, nx_mpv, nx_spv,
            nx_priv, nx_virt};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (vector %0d)", tag, act, exp, n_vec);
    end
  endtask

  // expected outcome of one request, worked out from the requirement list
  task automatic predict(output bit ex, output int cause, output logic [11:0] fld,
                         output bit swp, output string tag);
    int p; int np; int nv; int sie, spie, spp, mie, mpie, mpp, mpv, spv;
    bit mis;
    p = cur_priv; mis = tgt_bit1 && !rvc_enabled;
    ex = 0; cause = 0; tag = "";
    if (req_mret) begin
      if (p != 3)                          begin ex = 1; cause = 2;  tag = "R5"; end
      else if (mis)                        begin ex = 1; cause = 0;  tag = "R2"; end
      else if (!pmp_active && st_mpp != 3) begin ex = 1; cause = 2;  tag = "R6"; end
    end else begin
      if (p == 0)                          begin ex = 1; cause = 2;  tag = "R1"; end
      else if (mis)                        begin ex = 1; cause = 0;  tag = "R2"; end
      else if (st_tsr && p != 3)           begin ex = 1; cause = 2;  tag = "R3"; end
      else if (hyp_present && cur_virt && hs_vtsr)
                                           begin ex = 1; cause = 22; tag = "R4"; end
    end
    sie = st_sie; spie = st_spie; spp = st_spp; mie = st_mie; mpie = st_mpie;
    mpp = st_mpp; mpv = st_mpv; spv = hs_spv; np = p; nv = cur_virt;
    if (!ex) begin
      if (req_mret) begin
        tag = hyp_present ? "R11" : "R10";
        mie = st_mpie; mpie = 1; mpp = 0; mpv = 0; np = st_mpp;
        if (hyp_present) nv = st_mpv;
      end else begin
        sie = st_spie; spie = 1; spp = 0; np = st_spp;
        if (hyp_present && !cur_virt) begin
          tag = "R8"; nv = hs_spv; spv = 0;
        end else tag = "R9";
      end
    end
    fld = {sie[0], spie[0], spp[0], mie[0], mpie[0], mpp[1:0], mpv[0], spv[0],
           np[1:0], nv[0]};
    swp = !ex && nv == 1 && cur_virt == 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit ex; bit swp; int cause; logic [11:0] fld; logic [11:0] last; string tag;
    repeat (3) @(negedge clk);
    // R14 reset state
    check("R14 reset fields", {20'd0, out_fields()}, {20'd0, 12'b0000000_0_0_11_0});
    check("R14 reset strobes", {29'd0, done, exc_valid, bank_swap}, 32'd0);
    check("R14 reset cause", {27'd0, exc_cause}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 idle after reset", {29'd0, done, exc_valid, bank_swap}, 32'd0);
    for (int v = 0; v < NVEC; v++) begin
      req = 1;
      req_mret = v[0]; cur_priv = v[2:1]; cur_virt = v[3]; hyp_present = v[4];
      pmp_active = v[5]; rvc_enabled = v[6]; tgt_bit1 = v[7]; st_tsr = v[8];
      hs_vtsr = v[9]; st_spie = v[10]; st_spp = v[11]; st_mpie = v[12];
      st_mpp = v[14:13]; st_mpv = v[15]; hs_spv = v[16];
      st_sie = ~st_spie; st_mie = ~st_mpie;
      predict(ex, cause, fld, swp, tag);
      @(negedge clk);
      if (ex) begin
        check({tag, " cause"}, {27'd0, exc_cause}, cause);
        check("R7 exception strobes", {29'd0, done, exc_valid, bank_swap}, 32'd2);
        check("R7 exception fields unchanged", {20'd0, out_fields()}, {20'd0, fld});
      end else begin
        check({tag, " fields"}, {20'd0, out_fields()}, {20'd0, fld});
        check("R13 done strobe", {30'd0, done, exc_valid}, 32'd2);
        check("R12 bank swap", {31'd0, bank_swap}, {31'd0, swp});
      end
    end
    last = out_fields();
    req = 0; st_spie = ~st_spie; cur_priv = 2'd0;
    @(negedge clk);
    check("R13 idle strobes", {29'd0, done, exc_valid, bank_swap}, 32'd0);
    check("R13 idle hold", {20'd0, out_fields()}, {20'd0, last});
    finish_run();
  end

endmodule